// File: doc/BRIEF.md
# One-Address Accumulator Processor Core

This block is a small multi-cycle processor in which every instruction names at most one explicit register. The accumulator is always the implied first source and the implied destination. Each instruction is one byte. The opcode sits in the upper five bits and the register selector sits in the lower three bits. The core has eight general registers, an 8-bit accumulator and an 8-bit program counter.

The core talks to one synchronous memory port. That port carries both instructions and data, and read data arrives one clock after the address is presented. Each instruction steps through a fixed sequence of phases:

1. fetch the byte at the program counter;
2. capture it into an instruction register;
3. decode it into a held decode register;
4. execute it;
5. for a load only, wait one phase for the read data;
6. write the result back to the accumulator, a register or memory;
7. only then advance the program counter.

A halt instruction freezes the core until reset. Division by zero leaves the accumulator untouched and raises a sticky error flag.

Top module: `acc_core`

## Requirements
- R1: Synchronous active-high reset clears the program counter, accumulator, all registers and the error flag, and starts in the fetch phase. While and right after reset: `mem_addr`=0, `mem_we`=0, `halted`=0, `div_err`=0.
- R2: An instruction byte holds the opcode in bits 7:3 and the register index in bits 2:0. Opcode 00001 copies register r into AC. Opcode 00010 copies AC into register r.
- R3: Opcode 00011 loads AC from memory at the address held in r. Opcode 00100 writes AC to memory at the address held in r, with exactly one write strobe.
- R4: Opcode 00101 sets AC to AC+r and opcode 00110 sets AC to AC-r, both modulo 256.
- R5: Opcode 00111 sets AC to the low 8 bits of the unsigned product AC*r.
- R6: Opcode 01000 sets AC to the unsigned quotient AC/r when r is nonzero, and leaves `div_err` at 0.
- R7: Division by a zero register leaves AC unchanged and sets `div_err`. The flag stays set until reset.
- R8: Each instruction other than a load or a halt takes 6 clock cycles and a load takes 7. A halt raises `halted` 4 cycles after its fetch cycle begins. `mem_addr` shows the program counter outside load and store accesses.
- R9: The program counter advances by one per instruction and wraps from 255 to 0.
- R10: Opcode 00000 sets `halted`. After that, `halted` stays 1, `mem_addr` holds still and no memory write occurs until reset.
- R11: Every opcode from 01001 to 11111 is a no-op. It changes neither AC nor memory and takes 6 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory address: the program counter, or a register value during a load or store |
| mem_wdata | output | 8 | Store data, which is the accumulator |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |
| mem_we | output | 1 | Memory write strobe |
| halted | output | 1 | High once a halt has executed |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
Counting from the first rising edge after reset is released:
- An instruction stream with no loads fetches instruction k on the cycle after 6k edges.
- A load adds one edge.
- A halt shows `halted` 4 edges after its own fetch begins.

The bench therefore counts edges until `halted` appears and compares that count with the sum derived from the program. It samples only at falling edges. Results of the arithmetic are read from the bench memory after the store in the program has landed. The program-counter wrap is checked on the falling edge after edges 1530 and 1536 of a stream made only of no-ops.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned OPC_W    = 5;
    localparam int unsigned NUM_REGS = 8;
    localparam int unsigned SEL_W    = $clog2(NUM_REGS);
    localparam int unsigned INSN_W   = OPC_W + SEL_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  rsel_t;
    typedef logic [INSN_W-1:0] insn_t;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT  = 5'd0,
        OP_RD_R  = 5'd1,
        OP_WR_R  = 5'd2,
        OP_LOAD  = 5'd3,
        OP_STORE = 5'd4,
        OP_ADD   = 5'd5,
        OP_SUB   = 5'd6,
        OP_MUL   = 5'd7,
        OP_DIV   = 5'd8,
        OP_NOP   = 5'd31
    } opcode_e;

    typedef enum logic [2:0] {
        PH_FETCH, PH_LATCH, PH_DECODE, PH_EXEC,
        PH_LDWAIT, PH_WBACK, PH_PCUPD, PH_HALT
    } phase_e;

    typedef struct packed {
        opcode_e op;
        rsel_t   rsel;
        logic    wr_acc;
        logic    wr_reg;
        logic    is_load;
        logic    is_store;
        logic    is_halt;
    } decoded_t;

    typedef struct packed {
        phase_e   phase;
        word_t    pc;
        insn_t    ir;
        decoded_t dec;
        word_t    acc;
        word_t    res;
        logic     err;
    } core_state_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_core_pkg::*;
(
    input  insn_t    insn,
    output decoded_t dec
);
    logic [OPC_W-1:0] opfield;

    always_comb begin
        opfield      = insn[INSN_W-1:SEL_W];
        dec.rsel     = insn[SEL_W-1:0];
        dec.op       = OP_NOP;
        dec.wr_acc   = 1'b0;
        dec.wr_reg   = 1'b0;
        dec.is_load  = 1'b0;
        dec.is_store = 1'b0;
        dec.is_halt  = 1'b0;
        case (opfield)
            OP_HALT:  begin dec.op = OP_HALT;  dec.is_halt  = 1'b1; end
            OP_RD_R:  begin dec.op = OP_RD_R;  dec.wr_acc   = 1'b1; end
            OP_WR_R:  begin dec.op = OP_WR_R;  dec.wr_reg   = 1'b1; end
            OP_LOAD:  begin dec.op = OP_LOAD;  dec.wr_acc   = 1'b1; dec.is_load = 1'b1; end
            OP_STORE: begin dec.op = OP_STORE; dec.is_store = 1'b1; end
            OP_ADD:   begin dec.op = OP_ADD;   dec.wr_acc   = 1'b1; end
            OP_SUB:   begin dec.op = OP_SUB;   dec.wr_acc   = 1'b1; end
            OP_MUL:   begin dec.op = OP_MUL;   dec.wr_acc   = 1'b1; end
            OP_DIV:   begin dec.op = OP_DIV;   dec.wr_acc   = 1'b1; end
            default:  dec.op = OP_NOP;
        endcase
    end

    // R11: an undefined opcode never produces any write intent
    always_comb begin
        assert_nop_inert_R11: assert (dec.op != OP_NOP ||
            !(dec.wr_acc || dec.wr_reg || dec.is_store || dec.is_load || dec.is_halt))
            else $error("undefined opcode decoded with side effects");
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_core_pkg::*;
(
    input  opcode_e op,
    input  word_t   a,
    input  word_t   b,
    output word_t   y,
    output logic    div_zero
);
    logic [2*DATA_W-1:0] product;

    always_comb begin
        product  = a * b;
        div_zero = 1'b0;
        y        = a;
        case (op)
            OP_ADD: y = a + b;
            OP_SUB: y = a - b;
            OP_MUL: y = product[DATA_W-1:0];
            OP_DIV: begin
                if (b == '0) begin
                    div_zero = 1'b1;
                    y        = a;
                end else begin
                    y = a / b;
                end
            end
            default: y = a;
        endcase
    end
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
    parameter int unsigned NREG  = 8,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] regs_q [NREG];
    logic [WIDTH-1:0] regs_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            if (rst)
                regs_d[i] = '0;
            else if (we && waddr == AW'(i))
                regs_d[i] = wdata;
            else
                regs_d[i] = regs_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
    end

    assign rdata = regs_q[raddr];

    // R2: a register write is visible on the next cycle
    assert_rf_write_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> regs_q[$past(waddr)] == $past(wdata))
        else $error("register write lost");
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              halted,
    output logic              div_err
);
    core_state_t s_q, s_d;
    decoded_t    dec_w;
    word_t       rf_rdata, rf_wdata, alu_y;
    logic        rf_we, alu_div0;

    acc_decode u_decode (
        .insn (s_q.ir),
        .dec  (dec_w)
    );

    acc_alu u_alu (
        .op       (s_q.dec.op),
        .a        (s_q.acc),
        .b        (rf_rdata),
        .y        (alu_y),
        .div_zero (alu_div0)
    );

    acc_regfile #(.NREG(NUM_REGS), .WIDTH(DATA_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (s_q.dec.rsel),
        .wdata (rf_wdata),
        .raddr (s_q.dec.rsel),
        .rdata (rf_rdata)
    );

    always_comb begin
        s_d       = s_q;
        mem_addr  = s_q.pc;
        mem_wdata = s_q.acc;
        mem_we    = 1'b0;
        rf_we     = 1'b0;
        rf_wdata  = s_q.res;
        case (s_q.phase)
            PH_FETCH:  s_d.phase = PH_LATCH;
            PH_LATCH: begin
                s_d.ir    = mem_rdata;
                s_d.phase = PH_DECODE;
            end
            PH_DECODE: begin
                s_d.dec   = dec_w;
                s_d.phase = PH_EXEC;
            end
            PH_EXEC: begin
                s_d.phase = PH_WBACK;
                case (s_q.dec.op)
                    OP_HALT: s_d.phase = PH_HALT;
                    OP_LOAD: begin
                        mem_addr  = rf_rdata;
                        s_d.phase = PH_LDWAIT;
                    end
                    OP_RD_R: s_d.res = rf_rdata;
                    OP_WR_R: s_d.res = s_q.acc;
                    OP_ADD, OP_SUB, OP_MUL: s_d.res = alu_y;
                    OP_DIV: begin
                        s_d.res = alu_y;
                        if (alu_div0) s_d.err = 1'b1;
                    end
                    default: s_d.res = s_q.acc;
                endcase
            end
            PH_LDWAIT: begin
                s_d.res   = mem_rdata;
                s_d.phase = PH_WBACK;
            end
            PH_WBACK: begin
                if (s_q.dec.wr_acc) s_d.acc = s_q.res;
                if (s_q.dec.wr_reg) rf_we = 1'b1;
                if (s_q.dec.is_store) begin
                    mem_we   = 1'b1;
                    mem_addr = rf_rdata;
                end
                s_d.phase = PH_PCUPD;
            end
            PH_PCUPD: begin
                s_d.pc    = s_q.pc + 1'b1;
                s_d.phase = PH_FETCH;
            end
            default: s_d.phase = PH_HALT;
        endcase
        if (rst) begin
            s_d.phase        = PH_FETCH;
            s_d.pc           = '0;
            s_d.ir           = '0;
            s_d.dec.op       = OP_NOP;
            s_d.dec.rsel     = '0;
            s_d.dec.wr_acc   = 1'b0;
            s_d.dec.wr_reg   = 1'b0;
            s_d.dec.is_load  = 1'b0;
            s_d.dec.is_store = 1'b0;
            s_d.dec.is_halt  = 1'b0;
            s_d.acc          = '0;
            s_d.res          = '0;
            s_d.err          = 1'b0;
            rf_we            = 1'b0;
            mem_we           = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign halted  = (s_q.phase == PH_HALT);
    assign div_err = s_q.err;

    // R3: the strobe appears only in write-back of a store
    assert_we_wback_R3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (s_q.phase == PH_WBACK && s_q.dec.is_store))
        else $error("stray memory write");

    // R9: the program counter steps by one after the update phase
    assert_pc_step_R9: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_PCUPD) |=> s_q.pc == word_t'($past(s_q.pc) + 1'b1))
        else $error("pc step wrong");

    // R8: the program counter is held in every other phase
    assert_pc_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase != PH_PCUPD) |=> $stable(s_q.pc))
        else $error("pc moved outside update phase");

    // R8: the load wait phase only follows execution of a load
    assert_ldwait_R8: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_LDWAIT) |-> (s_q.dec.is_load && $past(s_q.phase) == PH_EXEC))
        else $error("load wait out of sequence");

    // R10: halt holds and never writes
    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !mem_we))
        else $error("halt released or wrote");

    // R7: the error flag is sticky
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        div_err |=> div_err)
        else $error("error flag dropped");

    // R7: divide by zero keeps the accumulator value as the result
    assert_div_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_EXEC && s_q.dec.op == OP_DIV && rf_rdata == '0)
        |=> (s_q.res == $past(s_q.acc) && div_err))
        else $error("divide by zero altered result");
endmodule

// File: tb/tb_acc_core.sv
`timescale 1ns/1ps
module tb_acc_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_we, halted, div_err;
    logic [7:0] mem [256];
    int         wr_cnt = 0;
    int         n_run  = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;

    acc_core dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .halted    (halted),
        .div_err   (div_err)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fill_mem(input logic [7:0] v);
        for (int i = 0; i < 256; i++) mem[i] = v;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        wr_cnt = 0;
    endtask

    task automatic run_to_halt(input int limit, output int edges);
        edges = 0;
        while (!halted && edges < limit) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
    endtask

    // R1: outputs right after reset
    task automatic t_reset();
        do_reset();
        chk(mem_addr == 8'd0, "R1 mem_addr", mem_addr, 0);
        chk(mem_we == 1'b0, "R1 mem_we", mem_we, 0);
        chk(halted == 1'b0, "R1 halted", halted, 0);
        chk(div_err == 1'b0, "R1 div_err", div_err, 0);
    endtask

    // Program: AC=24,r1=24,r3=1 via div, r4=25, r2=A, r5=B, AC=A op B, store at 25
    task automatic t_binop(input logic [7:0] opb, input logic [7:0] a, input logic [7:0] b,
                           input logic [7:0] exp, input bit exp_err, input string tag);
        int edges;
        fill_mem(8'h00);
        mem[0]  = 8'h18; mem[1]  = 8'h11; mem[2]  = 8'h41; mem[3]  = 8'h13;
        mem[4]  = 8'h09; mem[5]  = 8'h2B; mem[6]  = 8'h14; mem[7]  = 8'h19;
        mem[8]  = 8'h12; mem[9]  = 8'h1C; mem[10] = 8'h15; mem[11] = 8'h0A;
        mem[12] = opb;   mem[13] = 8'h24; mem[14] = 8'h00;
        mem[24] = a;     mem[25] = b;
        do_reset();
        run_to_halt(400, edges);
        chk(mem[25] == exp, {tag, " result"}, mem[25], exp);
        chk(div_err == exp_err, {tag, " R7 div_err"}, div_err, exp_err);
        // R8: 3 loads x7 + 11 others x6 + halt 4
        chk(edges == 91, {tag, " R8 cycles"}, edges, 91);
        // R3: one store, to the register address
        chk(wr_cnt == 1 && mem[24] == a, {tag, " R3 store"}, wr_cnt, 1);
    endtask

    // R10: halted state holds with no writes; R7 flag stays until reset
    task automatic t_halt_hold(input bit exp_err);
        logic [7:0] a0;
        a0 = mem_addr;
        repeat (20) @(negedge clk);
        chk(halted == 1'b1, "R10 halted held", halted, 1);
        chk(mem_addr == a0 && a0 == 8'd14, "R10 addr held", mem_addr, 14);
        chk(wr_cnt == 1, "R10 no writes", wr_cnt, 1);
        chk(div_err == exp_err, "R7 sticky", div_err, exp_err);
        do_reset();
        chk(div_err == 1'b0 && halted == 1'b0, "R1 reset clears flags", div_err, 0);
    endtask

    // R11: undefined opcodes leave AC alone; store AC=24 at 24
    task automatic t_nop();
        int edges;
        fill_mem(8'h00);
        mem[0] = 8'h18; mem[1] = 8'h11; mem[2] = 8'hF9; mem[3] = 8'h4A;
        mem[4] = 8'h21; mem[5] = 8'h00; mem[24] = 8'h99;
        do_reset();
        run_to_halt(400, edges);
        chk(mem[24] == 8'd24, "R11 AC kept", mem[24], 24);
        chk(edges == 35, "R11 R8 cycles", edges, 35);
        chk(wr_cnt == 1, "R11 no extra write", wr_cnt, 1);
    endtask

    // R9: pc steps and wraps over a stream of no-ops
    task automatic t_wrap();
        fill_mem(8'hF8);
        do_reset();
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(mem_addr == 8'd0, "R8 pc held mid-instruction", mem_addr, 0);
        @(posedge clk);
        @(negedge clk);
        chk(mem_addr == 8'd1, "R9 pc step", mem_addr, 1);
        repeat (1524) @(posedge clk);
        @(negedge clk);
        chk(mem_addr == 8'd255, "R9 pc at 255", mem_addr, 255);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(mem_addr == 8'd0, "R9 pc wrap", mem_addr, 0);
        chk(halted == 1'b0 && wr_cnt == 0, "R11 nops inert", wr_cnt, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_binop(8'h2D, 8'd7,   8'd5,   8'd12,  1'b0, "R4 R2 add");
        t_binop(8'h2D, 8'd100, 8'd200, 8'd44,  1'b0, "R4 add wrap");
        t_binop(8'h35, 8'd5,   8'd7,   8'd254, 1'b0, "R4 sub wrap");
        t_binop(8'h3D, 8'd20,  8'd13,  8'd4,   1'b0, "R5 mul");
        t_binop(8'h3D, 8'd255, 8'd255, 8'd1,   1'b0, "R5 mul max");
        t_binop(8'h45, 8'd200, 8'd7,   8'd28,  1'b0, "R6 div");
        t_binop(8'h45, 8'd5,   8'd9,   8'd0,   1'b0, "R6 div small");
        t_halt_hold(1'b0);
        t_binop(8'h45, 8'd77,  8'd0,   8'd77,  1'b1, "R7 div zero");
        t_halt_hold(1'b1);
        t_binop(8'h0D, 8'd3,   8'd9,   8'd9,   1'b0, "R2 mov");
        t_nop();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule